// File: doc/BRIEF.md
# Register Busy-Bit Hazard Tracker

This block tracks which architectural registers are the pending destination of an instruction that has left decode but not yet committed. It keeps one busy bit per register and no ordered list of destinations. Decode presents two optional source indices and one optional destination index every cycle. It gets back a single stall flag, which is high when any valid source reads a busy register (read-after-write) or the valid destination is already busy (write-after-write).

A single bit cannot count two writers of the same register, so the destination lookup keeps at most one in-flight writer per register. When decode raises the issue strobe and no stall is flagged, the destination bit is set. A commit port with its own index clears one bit. The commit is applied ahead of the lookups in the same cycle, so a dependant can issue in the cycle its producer commits. Register 0 is hard-wired and is never tracked.

Top module: `regbusy_tracker`

## Requirements
- R1: The tracker holds one busy bit for each of 32 registers, indexed 0 to 31 by a 5-bit index. An issue strobe with the stall output low and a valid nonzero destination sets that register's bit at the next clock edge.
- R2: A commit strobe with an index clears that register's bit at the next clock edge. The bit stays set until that commit arrives.
- R3: The stall output is high in any cycle where source A or source B is valid and names a busy register.
- R4: The stall output is high in any cycle where the destination is valid and names a busy register.
- R5: A source or destination whose valid flag is low never contributes to the stall output.
- R6: Register 0 is never busy. An issue with destination index 0 changes no bit.
- R7: A commit takes effect before that cycle's lookups, so a register being committed in a cycle does not cause a stall in that same cycle.
- R8: When an accepted issue and a commit name the same register in the same cycle, the bit is set afterwards.
- R9: An issue strobe raised while the stall output is high changes no bit.
- R10: A synchronous active-low reset clears every busy bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_vld | input | 1 | Source A is present |
| rd_a_idx | input | 5 | Source A register index |
| rd_b_vld | input | 1 | Source B is present |
| rd_b_idx | input | 5 | Source B register index |
| wr_vld | input | 1 | Destination is present |
| wr_idx | input | 5 | Destination register index |
| issue_en | input | 1 | Decode hands the instruction on this cycle |
| retire_vld | input | 1 | An in-flight instruction commits this cycle |
| retire_idx | input | 5 | Register written by the committing instruction |
| stall | output | 1 | Hazard found; decode must hold |

## Verification
On every cycle the assertions check the following:
- the stall flag rises whenever a valid source or destination meets a busy bit that is not being committed;
- no valid operand means no stall;
- an accepted issue leaves its bit set;
- a commit without a matching issue leaves its bit clear;
- a stalled issue changes nothing;
- register 0 stays idle;
- reset empties the vector.

The bench scenarios are needed to show that the full vector is correct, seen through source lookups over all 32 registers. They also cover the same-register issue-and-commit race, the same-cycle release of a dependant, and long random mixes with duplicate destinations, compared against an independent model.

// File: rtl/regbusy_pkg.sv
// Shared constants for the register busy-bit tracker.
// Assumes a power-of-two register count so every index value is a real register.
package regbusy_pkg;
    localparam int REG_COUNT    = 32;
    localparam int IDX_BITS     = $clog2(REG_COUNT);
    localparam int LOOKUP_PORTS = 3;

    // Order of the lookup ports inside the top module's arrays.
    typedef enum logic [1:0] {
        LK_SRC_A = 2'd0,
        LK_SRC_B = 2'd1,
        LK_DST   = 2'd2
    } lookup_port_e;
endpackage

// File: rtl/regbusy_decode.sv
// Turns a valid flag and a register index into a one-hot mask.
// With SKIP_ZERO set, index 0 produces an empty mask (hard-wired register).
// Assumes idx is below NUM_REGS.
module regbusy_decode #(
    parameter int NUM_REGS  = 32,
    parameter int IDX_W     = $clog2(NUM_REGS),
    parameter bit SKIP_ZERO = 1'b1
) (
    input  logic                vld,
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] mask
);
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_bit
            if (SKIP_ZERO && g == 0) begin : g_zero
                // Register 0 is never selected.
                assign mask[g] = 1'b0;
            end else begin : g_live
                // One comparator per register.
                assign mask[g] = vld && (idx == IDX_W'(g));
            end
        end
    endgenerate
endmodule

// File: rtl/regbusy_bits.sv
// Busy-bit storage: one flop per register.
// Clear is applied before set, so a same-cycle set wins.
// Also presents the vector as seen after this cycle's clear, which the lookups use.
module regbusy_bits #(
    parameter int NUM_REGS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REGS-1:0] set_mask,
    input  logic [NUM_REGS-1:0] clr_mask,
    output logic [NUM_REGS-1:0] busy_q,
    output logic [NUM_REGS-1:0] busy_eff
);
    logic [NUM_REGS-1:0] busy_d;

    // Current bits with this cycle's commit already removed.
    always_comb busy_eff = busy_q & ~clr_mask;

    // Next state: cleared bits, then newly issued bits on top.
    always_comb busy_d = busy_eff | set_mask;

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= busy_d;
    end
endmodule

// File: rtl/regbusy_lookup.sv
// One lookup port: reports whether a valid index names a busy register.
// Assumes idx is below NUM_REGS.
module regbusy_lookup #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] busy,
    input  logic                vld,
    input  logic [IDX_W-1:0]    idx,
    output logic                hit
);
    // Select the addressed bit; an absent operand never hits.
    always_comb hit = vld && busy[idx];
endmodule

// File: rtl/regbusy_tracker.sv
// Per-register busy-bit hazard tracker.
// Decode offers up to two sources and one destination and receives a stall flag.
// The stall covers read-after-write on the sources and write-after-write on the destination.
// An accepted issue (issue_en with stall low) marks the destination busy.
// A commit clears one bit, and it is seen by the same cycle's lookups.
// Register 0 is never tracked. Assumes indices are below NUM_REGS.
module regbusy_tracker #(
    parameter int NUM_REGS = regbusy_pkg::REG_COUNT,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_a_vld,
    input  logic [IDX_W-1:0] rd_a_idx,
    input  logic             rd_b_vld,
    input  logic [IDX_W-1:0] rd_b_idx,
    input  logic             wr_vld,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             issue_en,
    input  logic             retire_vld,
    input  logic [IDX_W-1:0] retire_idx,
    output logic             stall
);
    import regbusy_pkg::*;

    localparam int NLK = LOOKUP_PORTS;

    logic [NUM_REGS-1:0] set_mask;
    logic [NUM_REGS-1:0] clr_mask;
    logic [NUM_REGS-1:0] busy_q;
    logic [NUM_REGS-1:0] busy_eff;
    logic                accept;
    logic [NLK-1:0]      lk_vld;
    logic [IDX_W-1:0]    lk_idx [NLK];
    logic [NLK-1:0]      lk_hit;

    // Gather the three lookup operands into indexed arrays.
    always_comb begin
        lk_vld[LK_SRC_A] = rd_a_vld;
        lk_idx[LK_SRC_A] = rd_a_idx;
        lk_vld[LK_SRC_B] = rd_b_vld;
        lk_idx[LK_SRC_B] = rd_b_idx;
        lk_vld[LK_DST]   = wr_vld;
        lk_idx[LK_DST]   = wr_idx;
    end

    // Issue is accepted only when no hazard is flagged.
    always_comb accept = issue_en && !stall && wr_vld;

    regbusy_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SKIP_ZERO(1'b1)) u_set_dec (
        .vld  (accept),
        .idx  (wr_idx),
        .mask (set_mask)
    );

    regbusy_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SKIP_ZERO(1'b1)) u_clr_dec (
        .vld  (retire_vld),
        .idx  (retire_idx),
        .mask (clr_mask)
    );

    regbusy_bits #(.NUM_REGS(NUM_REGS)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .busy_q   (busy_q),
        .busy_eff (busy_eff)
    );

    genvar g;
    generate
        for (g = 0; g < NLK; g++) begin : g_lk
            regbusy_lookup #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_lk (
                .busy (busy_eff),
                .vld  (lk_vld[g]),
                .idx  (lk_idx[g]),
                .hit  (lk_hit[g])
            );
        end
    endgenerate

    // Any lookup hit holds decode.
    always_comb stall = |lk_hit;
endmodule

// File: rtl/regbusy_checker.sv
// Property checker for regbusy_tracker, attached by bind.
// Observes the ports and the stored busy vector.
module regbusy_checker #(
    parameter int NUM_REGS = 32,
    parameter int IDX_W    = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rd_a_vld,
    input logic [IDX_W-1:0]    rd_a_idx,
    input logic                rd_b_vld,
    input logic [IDX_W-1:0]    rd_b_idx,
    input logic                wr_vld,
    input logic [IDX_W-1:0]    wr_idx,
    input logic                issue_en,
    input logic                retire_vld,
    input logic [IDX_W-1:0]    retire_idx,
    input logic                stall,
    input logic [NUM_REGS-1:0] busy_q
);
    p_issue_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && !stall && wr_vld && wr_idx != '0) |=> busy_q[$past(wr_idx)]);

    p_commit_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !(issue_en && !stall && wr_vld && wr_idx == retire_idx))
        |=> !busy_q[$past(retire_idx)]);

    p_raw_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_vld && busy_q[rd_a_idx] && !(retire_vld && retire_idx == rd_a_idx)) |-> stall);

    p_raw_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_vld && busy_q[rd_b_idx] && !(retire_vld && retire_idx == rd_b_idx)) |-> stall);

    p_waw_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && busy_q[wr_idx] && !(retire_vld && retire_idx == wr_idx)) |-> stall);

    p_absent_ops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_a_vld && !rd_b_vld && !wr_vld) |-> !stall);

    p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q[0]);

    p_stalled_issue_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !retire_vld) |=> $stable(busy_q));

    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> busy_q == '0);
endmodule

bind regbusy_tracker regbusy_checker #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_a_vld   (rd_a_vld),
    .rd_a_idx   (rd_a_idx),
    .rd_b_vld   (rd_b_vld),
    .rd_b_idx   (rd_b_idx),
    .wr_vld     (wr_vld),
    .wr_idx     (wr_idx),
    .issue_en   (issue_en),
    .retire_vld (retire_vld),
    .retire_idx (retire_idx),
    .stall      (stall),
    .busy_q     (busy_q)
);

// File: tb/regbusy_tracker_test.sv
// Bench for regbusy_tracker: directed corners and seeded random traffic,
// compared against a bench-side busy model.
module regbusy_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 32;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rd_a_vld, rd_b_vld, wr_vld, issue_en, retire_vld;
    logic [IW-1:0] rd_a_idx, rd_b_idx, wr_idx, retire_idx;
    logic          stall;

    int            checks = 0;
    int            errors = 0;
    logic [NR-1:0] mdl;

    regbusy_tracker uut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_vld(rd_a_vld), .rd_a_idx(rd_a_idx),
        .rd_b_vld(rd_b_vld), .rd_b_idx(rd_b_idx),
        .wr_vld(wr_vld), .wr_idx(wr_idx),
        .issue_en(issue_en),
        .retire_vld(retire_vld), .retire_idx(retire_idx),
        .stall(stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model view of the bits after this cycle's commit.
    function automatic logic [NR-1:0] eff_bits(logic [NR-1:0] b, logic cv, logic [IW-1:0] ci);
        logic [NR-1:0] r;
        r = b;
        if (cv) r[ci] = 1'b0;
        return r;
    endfunction

    function automatic logic exp_stall(logic [NR-1:0] b, logic av, logic [IW-1:0] ai,
                                       logic bv, logic [IW-1:0] bi, logic dv, logic [IW-1:0] di,
                                       logic cv, logic [IW-1:0] ci);
        logic [NR-1:0] e;
        e = eff_bits(b, cv, ci);
        return (av && e[ai]) || (bv && e[bi]) || (dv && e[di]);
    endfunction

    function automatic logic [NR-1:0] exp_next(logic [NR-1:0] b, logic st, logic iss,
                                               logic dv, logic [IW-1:0] di,
                                               logic cv, logic [IW-1:0] ci);
        logic [NR-1:0] e;
        e = eff_bits(b, cv, ci);
        if (iss && !st && dv && di != '0) e[di] = 1'b1;
        return e;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: stall actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check stall, then let the rising edge act.
    task automatic cycle(string tag, logic av, logic [IW-1:0] ai, logic bv, logic [IW-1:0] bi,
                         logic dv, logic [IW-1:0] di, logic iss, logic cv, logic [IW-1:0] ci);
        logic es;
        rd_a_vld = av; rd_a_idx = ai; rd_b_vld = bv; rd_b_idx = bi;
        wr_vld = dv; wr_idx = di; issue_en = iss; retire_vld = cv; retire_idx = ci;
        #1;
        es = exp_stall(mdl, av, ai, bv, bi, dv, di, cv, ci);
        check(tag, stall, es);
        @(posedge clk);
        mdl = exp_next(mdl, es, iss, dv, di, cv, ci);
        @(negedge clk);
    endtask

    // Probe one register through source A with no other activity.
    task automatic probe(string tag, int r);
        cycle(tag, 1'b1, IW'(r), 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, '0);
    endtask

    task automatic probe_all(string tag);
        for (int r = 0; r < NR; r++) probe(tag, r);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        mdl = '0;
        rst_n = 1'b0;
        rd_a_vld = 0; rd_b_vld = 0; wr_vld = 0; issue_en = 0; retire_vld = 0;
        rd_a_idx = '0; rd_b_idx = '0; wr_idx = '0; retire_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: every bit clear after reset
        probe_all("R10 reset state");

        // R1: issue sets bit 5, seen through a source lookup
        cycle("R1 issue", 1'b0, '0, 1'b0, '0, 1'b1, 5'd5, 1'b1, 1'b0, '0);
        probe("R1 bit5 busy", 5);
        // R3: source B on busy reg stalls, absent source A on it does not
        cycle("R3 src b raw", 1'b0, 5'd5, 1'b1, 5'd5, 1'b0, '0, 1'b0, 1'b0, '0);
        // R5: invalid operands naming busy reg
        cycle("R5 absent ops", 1'b0, 5'd5, 1'b0, 5'd5, 1'b0, 5'd5, 1'b1, 1'b0, '0);
        // R4: second writer of reg 5 stalls; R9: its issue is dropped
        cycle("R4 waw", 1'b0, '0, 1'b0, '0, 1'b1, 5'd5, 1'b1, 1'b0, '0);
        // R9: stalled issue with another destination, sources on busy reg 5
        cycle("R9 stalled issue", 1'b1, 5'd5, 1'b0, '0, 1'b1, 5'd9, 1'b1, 1'b0, '0);
        probe("R9 bit9 idle", 9);
        // R7: commit of 5 releases a dependant in the same cycle
        cycle("R7 same-cycle release", 1'b1, 5'd5, 1'b0, '0, 1'b1, 5'd7, 1'b1, 1'b1, 5'd5);
        // R2: bit 5 now clear, bit 7 set
        probe("R2 bit5 cleared", 5);
        probe("R1 bit7 busy", 7);
        // R8: issue and commit on reg 7 in the same cycle leaves it set
        cycle("R8 race", 1'b0, '0, 1'b0, '0, 1'b1, 5'd7, 1'b1, 1'b1, 5'd7);
        probe("R8 bit7 still busy", 7);
        // R6: issue to reg 0 changes nothing
        cycle("R6 issue r0", 1'b0, '0, 1'b0, '0, 1'b1, 5'd0, 1'b1, 1'b0, '0);
        probe("R6 bit0 idle", 0);
        cycle("R2 commit 7", 1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 5'd7);
        probe_all("R2 all clear");

        // Random traffic on a small register window for frequent hazards.
        for (int n = 0; n < 3000; n++) begin
            logic av, bv, dv, iss, cv;
            logic [IW-1:0] ai, bi, di, ci;
            string tag;
            av = 1'($urandom_range(0, 1)); bv = 1'($urandom_range(0, 1));
            dv = ($urandom_range(0, 3) != 0); iss = ($urandom_range(0, 3) != 0);
            cv = ($urandom_range(0, 2) != 0);
            ai = IW'($urandom_range(0, 7)); bi = IW'($urandom_range(0, 7));
            di = IW'($urandom_range(0, 7)); ci = IW'($urandom_range(0, 7));
            if (!av && !bv && !dv) tag = "R5 random";
            else if (cv) tag = "R7 random";
            else tag = "R3 random";
            cycle(tag, av, ai, bv, bi, dv, di, iss, cv, ci);
        end
        probe_all("R1 final vector");

        // R10: reset mid-run with bits set
        cycle("R1 preload", 1'b0, '0, 1'b0, '0, 1'b1, 5'd31, 1'b1, 1'b1, 5'd31);
        rst_n = 1'b0;
        @(posedge clk);
        mdl = '0;
        @(negedge clk);
        rst_n = 1'b1;
        probe_all("R10 reset clears");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule